// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver

This block is the logic core of a column (segment) driver for a passive-matrix LCD. A row's worth of display data reaches it as 4-bit nibbles on a bus shared by a chain of identical drivers. Each falling edge of a shift strobe offers one nibble. A one-hot enable token inside the driver picks the group of four columns that receives the nibble. Once its 80 columns are filled, the driver stops accepting nibbles and raises its chain enable output, so the next driver in the chain takes over the bus. The controller needs no per-driver select line.

A falling edge on the line-load input copies the whole data register into an output latch and re-arms the token for the next row. Each column output is a 2-bit code for one of four drive levels. The code is selected by the latched pixel, the frame-alternation input and an active-low blanking input. A direction input mirrors the column order. It also swaps which chain pin listens and which one drives.

All strobes (shift, load) are level inputs. They are sampled in the `clk` domain, and their falling edges are detected there, so a strobe level must last at least one `clk` cycle.

Top module: `lcdseg_column_drv`

## Requirements
- R1: After reset the data register and output latch hold all zeros, the token points at the first nibble slot, and both chain outputs are low.
- R2: With `dir_rev`=0, a nibble is accepted on the `clk` edge where `shift_clk` is first seen low after being high, but only while `chain_a_in` is 1 and the driver is not full. The k-th accepted nibble since the last load (k=0..19) writes its bit j to column 4k+j.
- R3: With `dir_rev`=1, the enable input is `chain_b_in` and the enable output is `chain_a_out`, with `chain_a_oe`=1 and `chain_b_oe`=0 (forward: `chain_a_oe`=0, `chain_b_oe`=1). The k-th nibble's bit j goes to column 79-(4k+j).
- R4: The 20th accepted nibble sets the full state. From the next cycle the active chain output is 1, and later shift edges change nothing until a load. The inactive chain output stays 0.
- R5: Shift edges that arrive while the active enable input is 0 leave the data register unchanged.
- R6: A falling edge on `load` copies the data register into the latch and clears the full state. It also returns the token to slot 0. The data register keeps its contents, so a partial row overwrites only the slots it reaches.
- R7: When `load` and `shift_clk` fall in the same cycle, the load acts and that nibble is dropped.
- R8: With `blank_n`=1, column i shows code 2'b11 when lit and `alt`=1, code 2'b00 when lit and `alt`=0, code 2'b01 when unlit and `alt`=1, and code 2'b10 when unlit and `alt`=0. Column i occupies `seg_lvl[2i+1:2i]`.
- R9: With `blank_n`=0, every column shows code 2'b00, whatever the latch holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Nibble shift strobe; falling edge offers a nibble |
| nib | input | 4 | Nibble data bus |
| load | input | 1 | Line-load strobe; falling edge latches the row |
| dir_rev | input | 1 | 0: forward column order, 1: mirrored order and swapped chain pins |
| chain_a_in | input | 1 | Chain pin A, input side (enable in when forward) |
| chain_a_out | output | 1 | Chain pin A, output side (enable out when reversed) |
| chain_a_oe | output | 1 | Drive enable of chain pin A |
| chain_b_in | input | 1 | Chain pin B, input side (enable in when reversed) |
| chain_b_out | output | 1 | Chain pin B, output side (enable out when forward) |
| chain_b_oe | output | 1 | Drive enable of chain pin B |
| alt | input | 1 | Frame alternation |
| blank_n | input | 1 | Active-low blanking |
| seg_lvl | output | 160 | Two-bit drive-level code per column |

## Verification
The bench builds the block with its default 80 columns and 4-bit bus, so one row takes 20 nibbles. This size makes the full-detection boundary (19 versus 20 nibbles), the overflow nibble and the complete mirror in reverse order all reachable in a few hundred cycles. A reference model in the bench follows the token count and the data register, and predicts every latched row. That model also exposes partial rows after a load, nibbles dropped by a low enable input, and a load that falls together with a shift strobe.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

  typedef enum logic [1:0] {
    DRV_L0 = 2'b00,
    DRV_L1 = 2'b01,
    DRV_L2 = 2'b10,
    DRV_L3 = 2'b11
  } drv_lvl_e;

  // Nibble slot that feeds column outi.
  function automatic int src_slot(int outi, int cols, int bw, bit rev);
    int pos;
    pos = rev ? (cols - 1 - outi) : outi;
    return pos / bw;
  endfunction

  // Bit within the nibble that feeds column outi.
  function automatic int src_bit(int outi, int cols, int bw, bit rev);
    int pos;
    pos = rev ? (cols - 1 - outi) : outi;
    return pos % bw;
  endfunction

  // Drive level from pixel, alternation and blanking.
  function automatic drv_lvl_e pick_level(logic on_px, logic alt, logic blank_n);
    drv_lvl_e r;
    if (!blank_n)   r = DRV_L0;
    else if (on_px) r = alt ? DRV_L3 : DRV_L0;
    else            r = alt ? DRV_L1 : DRV_L2;
    return r;
  endfunction

endpackage

// File: rtl/lcdseg_fall.sv
module lcdseg_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/lcdseg_token.sv
module lcdseg_token #(
  parameter int SLOTS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_fall,
  input  logic             load_fall,
  input  logic             en_in,
  output logic             take,
  output logic [SLOTS-1:0] tok,
  output logic             full
);
  assign take = shift_fall & en_in & ~full & ~load_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok  <= SLOTS'(1);
      full <= 1'b0;
    end else if (load_fall) begin
      tok  <= SLOTS'(1);
      full <= 1'b0;
    end else if (take) begin
      tok <= {tok[SLOTS-2:0], tok[SLOTS-1]};
      if (tok[SLOTS-1]) full <= 1'b1;
    end
  end

  // R2
  token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) == 1);
  // R4
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tok[SLOTS-1]) |=> full);
  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !load_fall) |=> full);
  // R6
  load_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> (!full && tok[0]));
endmodule

// File: rtl/lcdseg_store.sv
module lcdseg_store
  import lcdseg_pkg::*;
#(
  parameter int COLS = 80,
  parameter int BW   = 4,
  localparam int SLOTS = COLS / BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             load_fall,
  input  logic             rev,
  input  logic [SLOTS-1:0] tok,
  input  logic [BW-1:0]    nib,
  output logic [COLS-1:0]  latch_q
);
  logic [COLS-1:0] data_q;

  for (genvar i = 0; i < COLS; i++) begin : g_col
    localparam int FS = src_slot(i, COLS, BW, 1'b0);
    localparam int FB = src_bit(i, COLS, BW, 1'b0);
    localparam int RS = src_slot(i, COLS, BW, 1'b1);
    localparam int RB = src_bit(i, COLS, BW, 1'b1);
    logic hit;
    assign hit = take & (rev ? tok[RS] : tok[FS]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   data_q[i] <= 1'b0;
      else if (hit) data_q[i] <= rev ? nib[RB] : nib[FB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= '0;
    else if (load_fall) latch_q <= data_q;
  end

  // R5
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(data_q));
  // R6
  latch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fall |=> $stable(latch_q));
endmodule

// File: rtl/lcdseg_levels.sv
module lcdseg_levels
  import lcdseg_pkg::*;
#(
  parameter int COLS = 80
) (
  input  logic [COLS-1:0]   latch_q,
  input  logic              alt,
  input  logic              blank_n,
  output logic [2*COLS-1:0] seg_lvl
);
  for (genvar i = 0; i < COLS; i++) begin : g_lvl
    assign seg_lvl[2*i +: 2] = pick_level(latch_q[i], alt, blank_n);
  end

  // R8
  always_comb begin
    if (blank_n && alt && latch_q[0])
      lit_alt_chk: assert (seg_lvl[1:0] == 2'b11);
  end
endmodule

// File: rtl/lcdseg_column_drv.sv
module lcdseg_column_drv #(
  parameter int COLS = 80,
  parameter int BW   = 4,
  localparam int SLOTS = COLS / BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_clk,
  input  logic [BW-1:0]     nib,
  input  logic              load,
  input  logic              dir_rev,
  input  logic              chain_a_in,
  output logic              chain_a_out,
  output logic              chain_a_oe,
  input  logic              chain_b_in,
  output logic              chain_b_out,
  output logic              chain_b_oe,
  input  logic              alt,
  input  logic              blank_n,
  output logic [2*COLS-1:0] seg_lvl
);
  logic             shift_fall;
  logic             load_fall;
  logic             en_in;
  logic             take;
  logic             full;
  logic [SLOTS-1:0] tok;
  logic [COLS-1:0]  latch_q;

  lcdseg_fall u_sf (.clk(clk), .rst_n(rst_n), .lvl(shift_clk), .fall(shift_fall));
  lcdseg_fall u_lf (.clk(clk), .rst_n(rst_n), .lvl(load),      .fall(load_fall));

  assign en_in = dir_rev ? chain_b_in : chain_a_in;

  lcdseg_token #(.SLOTS(SLOTS)) u_tok (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .load_fall(load_fall),
    .en_in(en_in), .take(take), .tok(tok), .full(full)
  );

  lcdseg_store #(.COLS(COLS), .BW(BW)) u_store (
    .clk(clk), .rst_n(rst_n), .take(take), .load_fall(load_fall),
    .rev(dir_rev), .tok(tok), .nib(nib), .latch_q(latch_q)
  );

  lcdseg_levels #(.COLS(COLS)) u_lvl (
    .latch_q(latch_q), .alt(alt), .blank_n(blank_n), .seg_lvl(seg_lvl)
  );

  assign chain_a_oe  = dir_rev;
  assign chain_b_oe  = ~dir_rev;
  assign chain_a_out = dir_rev & full;
  assign chain_b_out = ~dir_rev & full;

  // R9
  blank_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (seg_lvl == '0));
  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && shift_fall) |=> !full);
endmodule

// File: tb/tb_lcdseg_column_drv.sv
module tb_lcdseg_column_drv;
  localparam int COLS = 80;
  localparam int BW = 4;
  localparam int SLOTS = COLS / BW;

  logic clk = 0, rst_n = 0;
  logic shift_clk = 0, load = 0, dir_rev = 0;
  logic [BW-1:0] nib = '0;
  logic chain_a_in = 1, chain_b_in = 0, alt = 0, blank_n = 1;
  logic chain_a_out, chain_a_oe, chain_b_out, chain_b_oe;
  logic [2*COLS-1:0] seg_lvl;

  int nchecks = 0, nerr = 0;

  // bench reference model
  logic [COLS-1:0] m_data = '0, m_latch = '0;
  int m_cnt = 0;
  bit m_full = 0;

  logic [2*COLS-1:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  always #10 clk = ~clk;

  lcdseg_column_drv #(.COLS(COLS), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .nib(nib), .load(load),
    .dir_rev(dir_rev), .chain_a_in(chain_a_in), .chain_a_out(chain_a_out),
    .chain_a_oe(chain_a_oe), .chain_b_in(chain_b_in), .chain_b_out(chain_b_out),
    .chain_b_oe(chain_b_oe), .alt(alt), .blank_n(blank_n), .seg_lvl(seg_lvl)
  );

  function automatic logic [BW-1:0] pat(int seed, int k);
    return BW'(seed * 7 + k * 3 + k * k);
  endfunction

  function automatic logic [2*COLS-1:0] expect_seg(logic [COLS-1:0] px);
    logic [2*COLS-1:0] r;
    for (int i = 0; i < COLS; i++) begin
      if (!blank_n) r[2*i +: 2] = 2'b00;
      else          r[2*i +: 2] = {px[i] ? alt : ~alt, alt};
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic post(string tag);
    exp_q.push_back(expect_seg(m_latch));
    tag_q.push_back(tag);
    ->mon_ev;
    #1;
  endtask

  // monitor: pops expected rows and compares against the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        logic [2*COLS-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        nchecks++;
        if (seg_lvl !== e) begin
          nerr++;
          $display("FAIL %s act=%h exp=%h", t, seg_lvl, e);
        end
      end
    end
  end

  function automatic void model_take(logic [BW-1:0] v);
    bit en;
    en = dir_rev ? chain_b_in : chain_a_in;
    if (en && !m_full) begin
      for (int j = 0; j < BW; j++) begin
        int idx;
        idx = dir_rev ? COLS - 1 - (m_cnt * BW + j) : m_cnt * BW + j;
        m_data[idx] = v[j];
      end
      m_cnt++;
      if (m_cnt == SLOTS) m_full = 1;
    end
  endfunction

  task automatic shift(logic [BW-1:0] v);
    @(negedge clk); nib <= v; shift_clk <= 1;
    @(negedge clk); shift_clk <= 0;
    @(negedge clk);
    model_take(v);
  endtask

  task automatic do_load();
    @(negedge clk); load <= 1;
    @(negedge clk); load <= 0;
    @(negedge clk);
    m_latch = m_data; m_cnt = 0; m_full = 0;
  endtask

  task automatic both_fall(logic [BW-1:0] v);
    @(negedge clk); nib <= v; shift_clk <= 1; load <= 1;
    @(negedge clk); shift_clk <= 0; load <= 0;
    @(negedge clk);
    m_latch = m_data; m_cnt = 0; m_full = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 chain_a_out", chain_a_out, 0);
    chk("R1 chain_b_out", chain_b_out, 0);
    chk("R3 fwd oe", {chain_a_oe, chain_b_oe}, 2'b01);
    post("R1 reset row");

    // R2 forward row, R4 full boundary
    for (int k = 0; k < SLOTS - 1; k++) shift(pat(1, k));
    chk("R4 not full at 19", chain_b_out, 0);
    shift(pat(1, SLOTS - 1));
    chk("R4 full at 20", chain_b_out, 1);
    chk("R4 inactive pin", chain_a_out, 0);
    shift(4'hF); // R4 overflow nibble ignored
    chk("R4 still full", chain_b_out, 1);
    do_load();
    chk("R6 load clears full", chain_b_out, 0);
    alt = 1; #1;
    post("R2 forward row alt1");
    alt = 0; #1;
    post("R8 forward row alt0");

    // R5 enable low: nibbles dropped
    chain_a_in = 0;
    for (int k = 0; k < 5; k++) shift(pat(2, k));
    chain_a_in = 1;
    do_load();
    post("R5 enable low keeps data");

    // R6 partial row overwrites first slots only
    for (int k = 0; k < 3; k++) shift(pat(3, k));
    do_load();
    post("R6 partial row");

    // R7 coincident load and shift
    shift(4'h5); shift(4'hA);
    both_fall(4'h9);
    post("R7 coincident load");
    chk("R7 not full", chain_b_out, 0);
    shift(4'h6);
    do_load();
    post("R7 token restarted");

    // R3 reverse order and pin swap
    dir_rev = 1; alt = 1; #1;
    chk("R3 rev oe", {chain_a_oe, chain_b_oe}, 2'b10);
    shift(4'h3); shift(4'hC); // enable comes from pin B, which is low
    chain_b_in = 1;
    for (int k = 0; k < SLOTS; k++) shift(pat(4, k));
    chk("R3 rev enable out", chain_a_out, 1);
    chk("R3 rev other pin", chain_b_out, 0);
    do_load();
    post("R3 reverse row");

    // R9 blanking
    blank_n = 0; #1;
    post("R9 blank alt1");
    alt = 0; #1;
    post("R9 blank alt0");
    blank_n = 1; #1;
    post("R8 unblank");

    repeat (2) @(negedge clk);
    summary();
  end
endmodule